// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex serial port that moves one byte at a time over a single data line. It drives that line and also generates the shift clock that paces it. Every timing quantity is counted in cycles of the system clock `clk`. A bit cell lasts `CELL` clocks. The shift clock is low for the first `LOW` of them and high for the rest, and it idles high between transfers. The data line is split into an output, an output enable and an input. The tristate pad sits outside the block.

Software starts a transmit by pulsing `tx_wr` with a byte on `tx_byte`. Software starts a receive by pulsing `rx_flag_clr`, which clears the receive-done flag. During a transmit, each new bit appears `HOLD` clocks after the previous shift-clock rising edge. The first bit is driven during a short lead-in while the clock is still high, so it gets the same setup time as every later bit. During a receive, the input bit is captured on the same clock edge that raises the shift clock. At the end of the eighth bit cell the block raises the done flag for that direction. For a receive, it also loads the assembled byte into `rx_byte` on that same edge.

Top module: `ssp_sync_port`

## Requirements
In this section, "edge 0" means the rising edge of `clk` that accepts a request. "Cell c" spans edges 4+12c to 15+12c. All figures assume the defaults DW=8, CELL=12, LOW=6, HOLD=2 and least-significant bit first.
- R1: After reset, and whenever no transfer is running, `ser_clk` is 1 and `ser_oe` is 0. After reset, `tx_done`, `rx_done` and `rx_byte` are all 0.
- R2: A `tx_wr` pulse while idle starts a transmit of `tx_byte`. `ser_oe` is 1 from edge 0 to edge 99. Bit i of the byte (bit 0 first) is on `ser_dout` when the i-th shift-clock rising edge occurs.
- R3: Each cell drives `ser_clk` low for 6 clocks and then high for 6. The shift clock therefore rises exactly 8 times per transfer, with 12 clocks between rises. The first rise is at edge 10.
- R4: `ser_dout` changes only 2 clocks after a shift-clock rise. Each bit is valid at least 10 clocks before the rise that shifts it out, including bit 0, which is driven from edge 0.
- R5: An `rx_flag_clr` pulse while idle clears `rx_done` at edge 0 and starts a receive. `ser_din` is captured on each edge that raises `ser_clk`. The first captured value becomes bit 0 of the byte. No hold time after that edge is needed.
- R6: A transmit sets `tx_done` at edge 100. A new transmit start or a `tx_flag_clr` pulse clears it.
- R7: A receive sets `rx_done` at edge 100, and loads `rx_byte` with the captured byte on that same edge. `rx_byte` changes on no other edge.
- R8: A `tx_wr` or `rx_flag_clr` that arrives during a transfer is ignored. The byte in flight, the direction, the end time and the other flag are all unaffected.
- R9: If `tx_wr` and `rx_flag_clr` arrive in the same idle cycle, the transmit starts and the receive request is dropped. `rx_done` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bit timing is counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_wr | input | 1 | Write strobe to the transmit buffer; starts a transmit when idle |
| tx_byte | input | DW | Byte to transmit, taken with `tx_wr` |
| tx_flag_clr | input | 1 | Clears the transmit-done flag |
| rx_flag_clr | input | 1 | Clears the receive-done flag; starts a receive when idle |
| ser_din | input | 1 | Serial data from the line |
| ser_dout | output | 1 | Serial data to the line (1 when not driving) |
| ser_oe | output | 1 | Output enable for the data line |
| ser_clk | output | 1 | Shift clock, idles high |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |
| rx_byte | output | DW | Last received byte |

## Verification
The bench targets the following corner cases:
- **Lead-in of the first bit.** A design that drives bit 0 only when the first cell begins gives it 6 clocks of setup instead of 10.
- **Data-change offset.** A design that updates data on the rising edge itself, rather than 2 clocks after it, breaks both the hold check and the change-position check.
- **Receive sampling.** The bench changes `ser_din` right after each rise. A design that samples one clock late therefore captures the next bit and returns a byte shifted by one position.
- **Requests during a transfer.** The bench sends a second write and a flag clear in the middle of a transfer. A design that accepts them would corrupt the byte, flip `ser_oe`, or clear a flag it should leave alone.
- **Simultaneous requests.** When both requests arrive together, a design with the wrong priority starts a receive instead of a transmit.
- **Flag timing.** A flag raised one cell early or late, or an `rx_byte` loaded an edge before its flag, shows up as a wrong edge count.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   typedef enum logic {
      DIR_RX = 1'b0,
      DIR_TX = 1'b1
   } ssp_dir_e;
endpackage

// File: rtl/ssp_bit_timer.sv
// Bit-cell sequencer: a lead-in with the clock high, then DW cells of CELL
// clocks each. Emits the shift clock and the strobes that pace the shifter.
module ssp_bit_timer #(
   parameter int DW   = 8,
   parameter int CELL = 12,
   parameter int LOW  = 6,
   parameter int HOLD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic run,
   output logic sclk,
   output logic shift_stb,
   output logic samp_stb,
   output logic end_stb
);
   localparam int PW = $clog2(CELL);
   localparam int BW = (DW > 1) ? $clog2(DW) : 1;
   localparam logic [PW-1:0] PH_LAST = PW'(CELL - 1);
   localparam logic [PW-1:0] PH_UPD  = PW'(LOW + HOLD);
   localparam logic [PW-1:0] PH_PREU = PW'(LOW + HOLD - 1);
   localparam logic [PW-1:0] PH_PRER = PW'(LOW - 1);
   localparam logic [PW-1:0] PH_HIGH = PW'(LOW);
   localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

   logic [PW-1:0] ph;
   logic [BW-1:0] bitn;
   logic          lead;
   logic          in_cell;

   always_comb begin
      in_cell   = run && !lead;
      sclk      = !run || lead || (ph >= PH_HIGH);
      samp_stb  = in_cell && (ph == PH_PRER);
      shift_stb = in_cell && (ph == PH_PREU) && (bitn != BIT_LAST);
      end_stb   = in_cell && (ph == PH_LAST) && (bitn == BIT_LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= 1'b0;
         lead <= 1'b0;
         ph   <= '0;
         bitn <= '0;
      end else if (!run) begin
         if (start) begin
            run  <= 1'b1;
            lead <= 1'b1;
            ph   <= PH_UPD;
            bitn <= '0;
         end
      end else if (ph == PH_LAST) begin
         ph   <= '0;
         lead <= 1'b0;
         if (!lead) begin
            if (bitn == BIT_LAST) run <= 1'b0;
            else                  bitn <= bitn + 1'b1;
         end
      end else begin
         ph <= ph + 1'b1;
      end
   end
endmodule

// File: rtl/ssp_shifter.sv
// Shared shift register for both directions; bit order chosen by parameter.
module ssp_shifter #(
   parameter int DW        = 8,
   parameter bit MSB_FIRST = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] load_val,
   input  logic          tx_shift,
   input  logic          rx_samp,
   input  logic          din,
   output logic          out_bit,
   output logic [DW-1:0] word
);
   logic [DW-1:0] sreg;
   logic [DW-1:0] shifted;
   logic [DW-1:0] inserted;

   generate
      if (MSB_FIRST) begin : g_msb
         assign out_bit  = sreg[DW-1];
         assign shifted  = {sreg[DW-2:0], 1'b0};
         assign inserted = {sreg[DW-2:0], din};
      end else begin : g_lsb
         assign out_bit  = sreg[0];
         assign shifted  = {1'b0, sreg[DW-1:1]};
         assign inserted = {din, sreg[DW-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sreg <= '0;
      else if (load)     sreg <= load_val;
      else if (tx_shift) sreg <= shifted;
      else if (rx_samp)  sreg <= inserted;
   end

   assign word = sreg;
endmodule

// File: rtl/ssp_flag_ctrl.sv
// Request arbitration, direction latch, done flags and receive buffer.
module ssp_flag_ctrl
   import ssp_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_wr,
   input  logic          tx_flag_clr,
   input  logic          rx_flag_clr,
   input  logic          run,
   input  logic          end_stb,
   input  logic [DW-1:0] word,
   output logic          go_tx,
   output logic          start,
   output ssp_dir_e      dir,
   output logic          tx_done,
   output logic          rx_done,
   output logic [DW-1:0] rx_byte
);
   logic go_rx;
   logic fin_tx;
   logic fin_rx;

   always_comb begin
      go_tx  = tx_wr && !run;
      go_rx  = rx_flag_clr && !run && !tx_wr;
      start  = go_tx || go_rx;
      fin_tx = end_stb && (dir == DIR_TX);
      fin_rx = end_stb && (dir == DIR_RX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir     <= DIR_RX;
         tx_done <= 1'b0;
         rx_done <= 1'b0;
         rx_byte <= '0;
      end else begin
         if (go_tx)      dir <= DIR_TX;
         else if (go_rx) dir <= DIR_RX;

         if (fin_tx)                      tx_done <= 1'b1;
         else if (go_tx || tx_flag_clr)   tx_done <= 1'b0;

         if (fin_rx)     rx_done <= 1'b1;
         else if (go_rx) rx_done <= 1'b0;

         if (fin_rx)     rx_byte <= word;
      end
   end
endmodule

// File: rtl/ssp_sync_port.sv
module ssp_sync_port
   import ssp_pkg::*;
#(
   parameter int DW        = 8,
   parameter int CELL      = 12,
   parameter int LOW       = 6,
   parameter int HOLD      = 2,
   parameter bit MSB_FIRST = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_wr,
   input  logic [DW-1:0] tx_byte,
   input  logic          tx_flag_clr,
   input  logic          rx_flag_clr,
   input  logic          ser_din,
   output logic          ser_dout,
   output logic          ser_oe,
   output logic          ser_clk,
   output logic          tx_done,
   output logic          rx_done,
   output logic [DW-1:0] rx_byte
);
   generate
      if (DW < 2) begin : g_bad_dw
         $error("ssp_sync_port: DW must be at least 2");
      end
      if (LOW < 1 || HOLD < 1) begin : g_bad_phase
         $error("ssp_sync_port: LOW and HOLD must be at least 1");
      end
      if (LOW + HOLD >= CELL) begin : g_bad_cell
         $error("ssp_sync_port: LOW + HOLD must be below CELL");
      end
   endgenerate

   logic          run;
   logic          shift_stb;
   logic          samp_stb;
   logic          end_stb;
   logic          go_tx;
   logic          start;
   ssp_dir_e      dir;
   logic          out_bit;
   logic [DW-1:0] word;
   logic [DW-1:0] load_val;

   ssp_flag_ctrl #(.DW(DW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_flag_clr(tx_flag_clr),
      .rx_flag_clr(rx_flag_clr), .run(run), .end_stb(end_stb), .word(word),
      .go_tx(go_tx), .start(start), .dir(dir), .tx_done(tx_done),
      .rx_done(rx_done), .rx_byte(rx_byte)
   );

   ssp_bit_timer #(.DW(DW), .CELL(CELL), .LOW(LOW), .HOLD(HOLD)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start), .run(run), .sclk(ser_clk),
      .shift_stb(shift_stb), .samp_stb(samp_stb), .end_stb(end_stb)
   );

   assign load_val = go_tx ? tx_byte : '0;

   ssp_shifter #(.DW(DW), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(start), .load_val(load_val),
      .tx_shift(shift_stb && (dir == DIR_TX)),
      .rx_samp(samp_stb && (dir == DIR_RX)),
      .din(ser_din), .out_bit(out_bit), .word(word)
   );

   assign ser_oe   = run && (dir == DIR_TX);
   assign ser_dout = ser_oe ? out_bit : 1'b1;
endmodule

// File: rtl/ssp_sync_port_chk.sv
module ssp_sync_port_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run,
   input logic          ser_clk,
   input logic          ser_oe,
   input logic          ser_dout,
   input logic          tx_done,
   input logic          rx_done,
   input logic [DW-1:0] rx_byte
);
   AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (ser_clk && !ser_oe)); // R1
   AST_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_clk) |=> !ser_clk); // R3
   AST_SETUP_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $rose(ser_clk)) |-> $stable(ser_dout)); // R4
   AST_HOLD_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $rose(ser_clk)) |=> $stable(ser_dout)); // R4
   AST_TXDONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done) |-> (!run && $past(run) && $past(ser_oe))); // R6
   AST_RXBUF_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_byte) |-> $rose(rx_done)); // R7
   AST_DIR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> $stable(ser_oe)); // R8
endmodule

bind ssp_sync_port ssp_sync_port_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .ser_clk(ser_clk), .ser_oe(ser_oe),
   .ser_dout(ser_dout), .tx_done(tx_done), .rx_done(rx_done), .rx_byte(rx_byte)
);

// File: tb/sim_ssp_sync_port.sv
`timescale 1ns/1ps
module sim_ssp_sync_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_wr = 1'b0;
   logic [7:0] tx_byte = '0;
   logic       tx_flag_clr = 1'b0;
   logic       rx_flag_clr = 1'b0;
   logic       ser_din = 1'b1;
   logic       ser_dout, ser_oe, ser_clk, tx_done, rx_done;
   logic [7:0] rx_byte;

   int nchk = 0;
   int nfail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   ssp_sync_port u0 (
      .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_byte(tx_byte),
      .tx_flag_clr(tx_flag_clr), .rx_flag_clr(rx_flag_clr), .ser_din(ser_din),
      .ser_dout(ser_dout), .ser_oe(ser_oe), .ser_clk(ser_clk),
      .tx_done(tx_done), .rx_done(rx_done), .rx_byte(rx_byte)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit exp_bit(input logic [7:0] b, input int i);
      return b[i];
   endfunction

   // k counts negedges after the accepting edge; state after edge e shows at k=e+1
   task automatic run_tx(input logic [7:0] b, input bit poke, input bit both);
      int rises[8];
      logic [7:0] got = '0;
      int n = 0;
      int last_fall = 0;
      int done_k = 0;
      bit oe_bad = 1'b0;
      bit chg_bad = 1'b0;
      logic psclk, pdout;
      logic rxd_pre = rx_done;
      @(negedge clk);
      tx_wr = 1'b1; tx_byte = b; rx_flag_clr = both;
      @(negedge clk);
      tx_wr = 1'b0; rx_flag_clr = 1'b0;
      psclk = ser_clk; pdout = ser_dout;
      if (!ser_oe) oe_bad = 1'b1;
      for (int k = 2; k <= 104; k++) begin
         if (poke && k == 50) begin tx_wr = 1'b1; tx_byte = ~b; rx_flag_clr = 1'b1; end
         if (poke && k == 51) begin tx_wr = 1'b0; rx_flag_clr = 1'b0; end
         @(negedge clk);
         if (ser_clk && !psclk) begin
            if (n < 8) begin rises[n] = k; got[n] = ser_dout; end
            n++;
         end
         if (!ser_clk && psclk) last_fall = k;
         if (ser_dout != pdout && k <= 100)
            if (k < 13 || k > 85 || ((k - 13) % 12) != 0) chg_bad = 1'b1;
         if (k <= 100 && !ser_oe) oe_bad = 1'b1;
         if (tx_done && done_k == 0) done_k = k;
         psclk = ser_clk; pdout = ser_dout;
      end
      chk(got == b, "R2 byte shifted out", got, b);
      chk(!oe_bad, "R2 output enable held", oe_bad, 0);
      chk(n == 8, "R3 rise count", n, 8);
      if (n >= 8) begin
         for (int j = 1; j < 8; j++)
            chk(rises[j] - rises[j-1] == 12, "R3 cell period", rises[j] - rises[j-1], 12);
         chk(rises[7] - last_fall == 6, "R3 low width", rises[7] - last_fall, 6);
         chk(rises[0] - 1 == 10, "R4 first bit setup", rises[0] - 1, 10);
      end
      chk(!chg_bad, "R4 data change position", chg_bad, 0);
      chk(done_k == 101, "R6 tx_done timing", done_k, 101);
      if (poke) chk(rx_done == rxd_pre, "R8 rx flag untouched", rx_done, rxd_pre);
      if (both) chk(rx_done == rxd_pre, "R9 tx wins, rx flag kept", rx_done, rxd_pre);
   endtask

   task automatic run_rx(input logic [7:0] b, input bit poke);
      int n = 0;
      int done_k = 0;
      logic [7:0] buf_pre = rx_byte;
      logic [7:0] buf_at_prev = rx_byte;
      logic [7:0] buf_at_done = '0;
      bit oe_seen = 1'b0;
      logic psclk;
      logic txd_pre = tx_done;
      @(negedge clk);
      ser_din = exp_bit(b, 0);
      rx_flag_clr = 1'b1;
      @(negedge clk);
      rx_flag_clr = 1'b0;
      chk(rx_done == 1'b0, "R5 flag cleared at start", rx_done, 0);
      psclk = ser_clk;
      for (int k = 2; k <= 104; k++) begin
         if (poke && k == 50) begin tx_wr = 1'b1; tx_byte = ~b; rx_flag_clr = 1'b1; end
         if (poke && k == 51) begin tx_wr = 1'b0; rx_flag_clr = 1'b0; end
         buf_at_prev = (done_k == 0) ? rx_byte : buf_at_prev;
         @(negedge clk);
         if (ser_clk && !psclk) begin
            n++;
            ser_din = (n < 8) ? exp_bit(b, n) : ~exp_bit(b, 7);
         end
         if (ser_oe) oe_seen = 1'b1;
         if (rx_done && done_k == 0) begin done_k = k; buf_at_done = rx_byte; end
         psclk = ser_clk;
      end
      chk(buf_at_done == b, "R5 received byte", buf_at_done, b);
      chk(done_k == 101, "R7 rx_done timing", done_k, 101);
      chk(buf_at_prev == buf_pre, "R7 buffer waits for flag", buf_at_prev, buf_pre);
      chk(!oe_seen, "R5 line not driven on receive", oe_seen, 0);
      if (poke) chk(tx_done == txd_pre, "R8 tx request ignored", tx_done, txd_pre);
   endtask

   initial begin
      logic [7:0] r;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      chk(ser_clk == 1'b1 && ser_oe == 1'b0, "R1 idle line", {ser_clk, ser_oe}, 2);
      chk(tx_done == 1'b0 && rx_done == 1'b0, "R1 flags", {tx_done, rx_done}, 0);
      chk(rx_byte == 8'h00, "R1 buffer", rx_byte, 0);
      rst_n = 1'b1;
      @(negedge clk);
      run_tx(8'hA5, 1'b0, 1'b0);
      run_tx(8'h01, 1'b0, 1'b0);
      run_tx(8'h80, 1'b0, 1'b0);
      run_rx(8'h00, 1'b0);
      run_rx(8'hFF, 1'b0);
      run_rx(8'h5A, 1'b0);
      run_tx(8'h3C, 1'b1, 1'b0);
      run_rx(8'hC3, 1'b1);
      run_tx(8'h96, 1'b0, 1'b1);
      @(negedge clk);
      tx_flag_clr = 1'b1;
      @(negedge clk);
      tx_flag_clr = 1'b0;
      chk(tx_done == 1'b0, "R6 flag cleared by software", tx_done, 0);
      for (int i = 0; i < 6; i++) begin
         r = 8'($urandom);
         run_tx(r, 1'b0, 1'b0);
         r = 8'($urandom);
         run_rx(r, 1'b0);
      end
      finished = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end
endmodule